// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block sits inside one bank of a parallel NOR flash device. It answers host reads while an embedded program or erase is running. It treats both operations as timed busy periods and does not model cell storage. The command decoder raises a one-cycle strobe when the last write-enable pulse of a command sequence rises. The strobe comes with the operation type and the target information. For a program, the target is an address and the value written to status bit 7. For an erase, it is a sector-select mask. A sector-protect map comes in alongside.

While the bank is busy, every read returns a status word in place of array contents. Bit 7 of that word signals progress by polarity: the inverse of the programmed bit during a program, and 0 during an erase. All other bits of the status word are 0. A level-sensitive suspend request pauses an erase, and a program may run inside that pause. The caller supplies array data on `cell_data` for the address on `rd_addr`. The block passes that data through in read mode and for sectors not under erase while suspended. A ready flag and a two-bit bank mode show the state.

Top module: `fstat_responder`

## Requirements
- R1: After reset, bank_mode is 0 (READ), ry_by is 1 and rd_data is 0.
- R2: In READ mode, a read (rd_en high at a clock edge) loads cell_data into rd_data after that edge. rd_data holds its value in every cycle where rd_en is low.
- R3: A program command to an unprotected sector sets bank_mode to 1 (PROG) for PROG_CYC cycles, with ry_by 0. Reads during that time return a word whose bit 7 is the inverse of prog_msb and whose other bits are 0.
- R4: A read in the last busy cycle of a program or erase returns a word whose bit 7 holds the final value (prog_msb for a program, 1 for an erase) and whose other bits are 0. Reads after that return full array data.
- R5: A program command to a protected sector keeps PROG for PROT_PROG_CYC cycles, shows the same status, then returns to READ. The sector is the top SECT_W bits of the address, and prot_map bit s protects sector s.
- R6: An erase command whose mask (erase_sel bit s selects sector s) has at least one unprotected sector sets bank_mode to 2 (ERASE) for ERASE_CYC cycles, with ry_by 0. Reads return an all-zero word at any address, including protected selected sectors.
- R7: An erase command with no selected unprotected sector holds ERASE for PROT_ERASE_CYC cycles, then returns to READ.
- R8: susp_req high during ERASE (before its last cycle) moves the bank to 3 (SUSP) after the next edge, freezes the remaining erase time and sets ry_by to 1. In SUSP, reads at a sector being erased return 16'h0080, and other reads return cell_data. Lowering susp_req returns the bank to ERASE.
- R9: A program command in SUSP runs exactly as in R3/R5 and then returns to SUSP, not READ.
- R10: Command strobes are ignored in PROG and ERASE. An erase strobe is ignored in SUSP. susp_req is ignored outside ERASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_done | input | 1 | One-cycle strobe at the rising edge of the final write-enable pulse |
| cmd_erase | input | 1 | Operation type with cmd_done: 1 erase, 0 program |
| prog_addr | input | ADDR_W | Program target address |
| prog_msb | input | 1 | Value being written to data bit 7 |
| erase_sel | input | NUM_SECT | Sectors selected for erase |
| prot_map | input | NUM_SECT | Per-sector protection, 1 = protected |
| susp_req | input | 1 | Erase suspend request (level) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| cell_data | input | DATA_W | Array data for rd_addr |
| rd_data | output | DATA_W | Registered read result |
| ry_by | output | 1 | 1 ready, 0 busy with embedded operation |
| bank_mode | output | 2 | 0 READ, 1 PROG, 2 ERASE, 3 SUSP |

## Verification
The assertions assume that cmd_done is a single-cycle pulse and that cmd_erase, prog_addr, prog_msb and the masks are valid in that cycle. They also assume that cell_data settles in the same cycle as rd_addr. The bench drives every input at the falling clock edge and keeps the masks unchanged through each erase. It computes cell_data as a fixed function of rd_addr, so the stimulus stays within these assumptions. Strobes sent during busy periods and suspend requests outside erase are deliberate, because the properties define the ignoring behaviour for them.

// File: rtl/fstat_pkg.sv
`timescale 1ns/1ps
package fstat_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_SUSP  = 2'd3
    } bank_mode_e;

    localparam int STAT_BIT = 7;
endpackage

// File: rtl/fstat_sector_hit.sv
`timescale 1ns/1ps
module fstat_sector_hit #(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2,
    localparam int NUM_SECT = 1 << SECT_W
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_SECT-1:0] mask,
    output logic                hit
);
    logic [SECT_W-1:0] sect;

    always_comb begin
        sect = addr[ADDR_W-1 -: SECT_W];
        hit  = mask[sect];
    end
endmodule

// File: rtl/fstat_ctrl.sv
`timescale 1ns/1ps
module fstat_ctrl
    import fstat_pkg::*;
#(
    parameter int NUM_SECT       = 4,
    parameter int CNT_W          = 8,
    parameter int PROG_CYC       = 12,
    parameter int ERASE_CYC      = 40,
    parameter int PROT_PROG_CYC  = 5,
    parameter int PROT_ERASE_CYC = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_done,
    input  logic                cmd_erase,
    input  logic                prog_msb,
    input  logic                prog_prot,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic [NUM_SECT-1:0] prot_map,
    input  logic                susp_req,
    output bank_mode_e          mode,
    output logic                prog_last,
    output logic                erase_last,
    output logic                prog_bit,
    output logic [NUM_SECT-1:0] erase_set
);
    localparam logic [CNT_W-1:0] PROG_LD   = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LD  = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PPROG_LD  = CNT_W'(PROT_PROG_CYC - 1);
    localparam logic [CNT_W-1:0] PERASE_LD = CNT_W'(PROT_ERASE_CYC - 1);

    typedef struct packed {
        bank_mode_e          mode;
        logic [CNT_W-1:0]    pcnt;
        logic [CNT_W-1:0]    ecnt;
        logic                pbit;
        logic                back_susp;
        logic [NUM_SECT-1:0] eset;
    } ctl_t;

    ctl_t st_q, st_d;
    logic [NUM_SECT-1:0] live_d;

    always_comb begin
        st_d   = st_q;
        live_d = erase_sel & ~prot_map;
        unique case (st_q.mode)
            MODE_READ: begin
                if (cmd_done) begin
                    if (cmd_erase) begin
                        st_d.mode = MODE_ERASE;
                        st_d.eset = live_d;
                        st_d.ecnt = (|live_d) ? ERASE_LD : PERASE_LD;
                    end else begin
                        st_d.mode      = MODE_PROG;
                        st_d.pbit      = prog_msb;
                        st_d.back_susp = 1'b0;
                        st_d.pcnt      = prog_prot ? PPROG_LD : PROG_LD;
                    end
                end
            end
            MODE_PROG: begin
                if (st_q.pcnt == '0) begin
                    st_d.mode = st_q.back_susp ? MODE_SUSP : MODE_READ;
                end else begin
                    st_d.pcnt = st_q.pcnt - 1'b1;
                end
            end
            MODE_ERASE: begin
                if (st_q.ecnt == '0) begin
                    st_d.mode = MODE_READ;
                    st_d.eset = '0;
                end else if (susp_req) begin
                    st_d.mode = MODE_SUSP;
                end else begin
                    st_d.ecnt = st_q.ecnt - 1'b1;
                end
            end
            MODE_SUSP: begin
                if (cmd_done && !cmd_erase) begin
                    st_d.mode      = MODE_PROG;
                    st_d.pbit      = prog_msb;
                    st_d.back_susp = 1'b1;
                    st_d.pcnt      = prog_prot ? PPROG_LD : PROG_LD;
                end else if (!susp_req) begin
                    st_d.mode = MODE_ERASE;
                end
            end
            default: st_d.mode = MODE_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_READ, pcnt: '0, ecnt: '0, pbit: 1'b0,
                      back_susp: 1'b0, eset: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode       = st_q.mode;
    assign prog_last  = (st_q.mode == MODE_PROG) && (st_q.pcnt == '0);
    assign erase_last = (st_q.mode == MODE_ERASE) && (st_q.ecnt == '0);
    assign prog_bit   = st_q.pbit;
    assign erase_set  = st_q.eset;

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PROG && cmd_done && !prog_last) |=> (mode == MODE_PROG && $stable(prog_bit)));

    // R8
    susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERASE && !erase_last && susp_req) |=> (mode == MODE_SUSP && $stable(st_q.ecnt)));

    // R9
    susp_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_last && st_q.back_susp) |=> (mode == MODE_SUSP));

    // R7
    prot_erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ && cmd_done && cmd_erase && ((erase_sel & ~prot_map) == '0))
        |=> (mode == MODE_ERASE && st_q.ecnt == PERASE_LD && erase_set == '0));

    // R5
    prot_prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ && cmd_done && !cmd_erase && prog_prot) |=> (st_q.pcnt == PPROG_LD));
endmodule

// File: rtl/fstat_rdpath.sv
`timescale 1ns/1ps
module fstat_rdpath
    import fstat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  bank_mode_e        mode,
    input  logic              prog_last,
    input  logic              erase_last,
    input  logic              prog_bit,
    input  logic              rd_in_eset,
    input  logic [DATA_W-1:0] cell_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_d, rd_d, rd_q;

    always_comb begin
        word_d = '0;
        unique case (mode)
            MODE_READ:  word_d = cell_data;
            MODE_PROG:  word_d[STAT_BIT] = prog_last ? prog_bit : ~prog_bit;
            MODE_ERASE: word_d[STAT_BIT] = erase_last;
            MODE_SUSP: begin
                if (rd_in_eset) word_d[STAT_BIT] = 1'b1;
                else            word_d = cell_data;
            end
            default: word_d = '0;
        endcase
        rd_d = rd_en ? word_d : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R6
    erase_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == MODE_ERASE && !erase_last) |=> (rd_data == '0));

    // R3
    prog_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode == MODE_PROG && !prog_last) |=> (rd_data[STAT_BIT] != $past(prog_bit)));

    // R4
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && prog_last) |=> (rd_data[STAT_BIT] == $past(prog_bit)));
endmodule

// File: rtl/fstat_responder.sv
`timescale 1ns/1ps
module fstat_responder
    import fstat_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int SECT_W         = 2,
    parameter int DATA_W         = 16,
    parameter int PROG_CYC       = 1400,
    parameter int ERASE_CYC      = 100000,
    parameter int PROT_PROG_CYC  = 200,
    parameter int PROT_ERASE_CYC = 20000,
    localparam int NUM_SECT      = 1 << SECT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_done,
    input  logic                cmd_erase,
    input  logic [ADDR_W-1:0]   prog_addr,
    input  logic                prog_msb,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic [NUM_SECT-1:0] prot_map,
    input  logic                susp_req,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   cell_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic                ry_by,
    output logic [1:0]          bank_mode
);
    localparam int MAX_A  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_B  = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    bank_mode_e          mode;
    logic                prog_prot, rd_in_eset, prog_last, erase_last, prog_bit;
    logic [NUM_SECT-1:0] erase_set;

    fstat_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_prot_hit (
        .addr(prog_addr), .mask(prot_map), .hit(prog_prot)
    );

    fstat_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_eset_hit (
        .addr(rd_addr), .mask(erase_set), .hit(rd_in_eset)
    );

    fstat_ctrl #(
        .NUM_SECT(NUM_SECT), .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_erase(cmd_erase),
        .prog_msb(prog_msb), .prog_prot(prog_prot), .erase_sel(erase_sel),
        .prot_map(prot_map), .susp_req(susp_req), .mode(mode), .prog_last(prog_last),
        .erase_last(erase_last), .prog_bit(prog_bit), .erase_set(erase_set)
    );

    fstat_rdpath #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mode(mode), .prog_last(prog_last),
        .erase_last(erase_last), .prog_bit(prog_bit), .rd_in_eset(rd_in_eset),
        .cell_data(cell_data), .rd_data(rd_data)
    );

    assign bank_mode = mode;
    assign ry_by     = (mode == MODE_READ) || (mode == MODE_SUSP);

    // R3
    busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ry_by && cmd_done && !cmd_erase) |=> (!ry_by && bank_mode == 2'd1));

    // R10
    susp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_mode == 2'd0 && susp_req && !cmd_done) |=> (bank_mode == 2'd0));
endmodule

// File: tb/sim_fstat_responder.sv
`timescale 1ns/1ps
module sim_fstat_responder;
    localparam int AW = 8, SW = 2, DW = 16, NS = 4;
    localparam int PC = 12, EC = 40, PPC = 5, PEC = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_done = 1'b0, cmd_erase = 1'b0, prog_msb = 1'b0, susp_req = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] prog_addr = '0, rd_addr = '0;
    logic [NS-1:0] erase_sel = '0, prot_map = '0;
    logic [DW-1:0] cell_data, rd_data;
    logic ry_by;
    logic [1:0] bank_mode;
    int n_chk = 0, n_fail = 0;

    assign cell_data = {rd_addr, ~rd_addr};
    always #2.5 clk = ~clk;

    fstat_responder #(
        .ADDR_W(AW), .SECT_W(SW), .DATA_W(DW), .PROG_CYC(PC), .ERASE_CYC(EC),
        .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_erase(cmd_erase),
        .prog_addr(prog_addr), .prog_msb(prog_msb), .erase_sel(erase_sel),
        .prot_map(prot_map), .susp_req(susp_req), .rd_en(rd_en), .rd_addr(rd_addr),
        .cell_data(cell_data), .rd_data(rd_data), .ry_by(ry_by), .bank_mode(bank_mode)
    );

    // behavioural reference
    int m_mode = 0, m_pc = 0, m_ec = 0;
    bit m_pbit = 0, m_back = 0;
    bit [NS-1:0] m_eset = '0;
    logic [DW-1:0] m_rd = '0;
    string t_mode = "R1", t_rd = "R1";

    task automatic start_prog(input bit from_susp);
        bit prot;
        prot   = prot_map[prog_addr[AW-1 -: SW]];
        m_pc   = prot ? PPC - 1 : PC - 1;
        m_pbit = prog_msb;
        m_back = from_susp;
        m_mode = 1;
        t_mode = from_susp ? "R9" : (prot ? "R5" : "R3");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pc = 0; m_ec = 0; m_pbit = 0; m_back = 0; m_eset = '0;
            m_rd = '0; t_mode = "R1"; t_rd = "R1";
        end else begin
            if (rd_en) begin
                m_rd = '0;
                case (m_mode)
                    0: begin m_rd = cell_data; t_rd = "R2"; end
                    1: begin
                        m_rd[7] = (m_pc == 0) ? m_pbit : !m_pbit;
                        t_rd = (m_pc == 0) ? "R4" : (m_back ? "R9" : "R3");
                    end
                    2: begin m_rd[7] = (m_ec == 0); t_rd = (m_ec == 0) ? "R4" : "R6"; end
                    default: begin
                        if (m_eset[rd_addr[AW-1 -: SW]]) m_rd[7] = 1'b1;
                        else m_rd = cell_data;
                        t_rd = "R8";
                    end
                endcase
            end
            case (m_mode)
                0: begin
                    if (susp_req) t_mode = "R10";
                    if (cmd_done) begin
                        if (cmd_erase) begin
                            m_eset = erase_sel & ~prot_map;
                            m_mode = 2;
                            if (m_eset != 0) begin m_ec = EC - 1; t_mode = "R6"; end
                            else begin m_ec = PEC - 1; t_mode = "R7"; end
                        end else start_prog(1'b0);
                    end
                end
                1: begin
                    if (cmd_done) t_mode = "R10";
                    if (m_pc == 0) m_mode = m_back ? 3 : 0;
                    else m_pc--;
                end
                2: begin
                    if (cmd_done) t_mode = "R10";
                    if (m_ec == 0) begin m_mode = 0; m_eset = '0; end
                    else if (susp_req) begin m_mode = 3; t_mode = "R8"; end
                    else m_ec--;
                end
                default: begin
                    if (cmd_done && !cmd_erase) start_prog(1'b1);
                    else begin
                        if (cmd_done) t_mode = "R10";
                        if (!susp_req) m_mode = 2;
                    end
                end
            endcase
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check(t_mode, 32'(bank_mode), 32'(m_mode));
        check(t_mode, 32'(ry_by), 32'(m_mode == 0 || m_mode == 3));
        check(t_rd, 32'(rd_data), 32'(m_rd));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cmd(input bit erase);
        cmd_erase = erase; cmd_done = 1'b1;
        tick(1);
        cmd_done = 1'b0;
    endtask

    task automatic read_run(input int n, input logic [AW-1:0] a0, input logic [AW-1:0] a1);
        rd_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            rd_addr = i[0] ? a1 : a0;
            tick(1);
        end
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        tick(4);
        // R1 reset values are compared on every cycle above
        rst_n = 1'b1;
        tick(2);
        // R2 plain reads, then idle to show hold
        read_run(3, 8'h35, 8'hA7);
        tick(3);
        // R3 / R4 program, bit 7 = 1, read through completion; R10 strobe mid-way
        prog_addr = 8'h10; prog_msb = 1'b1;
        pulse_cmd(1'b0);
        read_run(4, 8'h10, 8'h10);
        pulse_cmd(1'b1);
        read_run(PC, 8'h10, 8'h11);
        tick(2);
        // R3 program, bit 7 = 0
        prog_msb = 1'b0;
        pulse_cmd(1'b0);
        read_run(PC + 3, 8'h12, 8'h13);
        // R5 protected program
        prot_map = 4'b0100; prog_addr = 8'h80; prog_msb = 1'b1;
        pulse_cmd(1'b0);
        read_run(PPC + 3, 8'h80, 8'h81);
        // R6 partially protected erase, reads in erased and protected sectors
        erase_sel = 4'b0110;
        pulse_cmd(1'b1);
        read_run(EC + 3, 8'h40, 8'h90);
        // R7 erase with every selected sector protected
        erase_sel = 4'b0100;
        pulse_cmd(1'b1);
        read_run(PEC + 3, 8'h85, 8'h05);
        // R8 / R9 / R10 suspend flow
        prot_map = 4'b0000; erase_sel = 4'b0011;
        pulse_cmd(1'b1);
        tick(10);
        susp_req = 1'b1;
        tick(2);
        read_run(4, 8'h05, 8'hC5);
        pulse_cmd(1'b1);
        prog_addr = 8'hC0; prog_msb = 1'b1;
        pulse_cmd(1'b0);
        read_run(PC + 3, 8'hC0, 8'h45);
        susp_req = 1'b0;
        read_run(EC, 8'h05, 8'hC5);
        // R10 suspend request while idle
        susp_req = 1'b1;
        read_run(3, 8'h22, 8'h23);
        susp_req = 1'b0;
        tick(3);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all R tags): actual still running expected finished");
        summary();
        $finish;
    end
endmodule